// File: doc/BRIEF.md
# Dual-Control Up/Down Counter

This block is a small synchronous binary counter whose counting direction comes from two separate control pins rather than one direction bit. On every rising clock edge it steps up by one, steps down by one, or keeps its value. Which of these happens depends on how the two controls `inc_req` and `dec_req` are set. When both are low or both are high, the count holds.

Each count bit is held in its own toggle-style register. A bit flips when it is allowed to toggle. When counting up, that is when every less significant bit is 1. When counting down, it is when every less significant bit is 0. Because of this, the count wraps around at both ends. The width is a parameter with a default of three bits. The count leaves the block directly from the bit registers.

Top module: `updn_counter2in`

## Requirements
- R1: The count is `CNT_W` bits wide, default 3, and takes the values 0 to 2^CNT_W-1. Counting up from 0 returns to 0 after exactly 2^CNT_W steps.
- R2: With `inc_req`=1 and `dec_req`=0 at a rising edge, the count after that edge is the previous count plus one.
- R3: With `inc_req`=0 and `dec_req`=1 at a rising edge, the count after that edge is the previous count minus one.
- R4: With both controls at 0 at a rising edge, the count keeps its value.
- R5: With both controls at 1 at a rising edge, the count keeps its value.
- R6: Counting up from the all-ones value (7 at the default width) gives 0.
- R7: Counting down from 0 gives the all-ones value (7 at the default width).
- R8: A high `rst` at a rising edge clears the count to 0, whatever the controls are.
- R9: The controls are sampled only at the rising edge. A pulse on them that starts and ends between two edges leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inc_req | input | 1 | Count-up control |
| dec_req | input | 1 | Count-down control |
| count | output | CNT_W | Registered count value |

## Verification
On every cycle, the assertions check that the count responds correctly to the pair of controls sampled at the previous edge. An up request must add one, a down request must subtract one, and equal controls must hold the value. The assertions also check that both wrap points land on the correct value and that reset forces zero. Two things can only be shown by the bench's scenarios. One is that a pulse on the controls between edges leaves no trace. The other is that a full sweep returns to zero after exactly eight steps at the default width.

// File: rtl/updn_pkg.sv
package updn_pkg;

  localparam int CNT_W_DEFAULT = 3;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;

  function automatic dir_e decode_dir(input logic up_i, input logic down_i);
    if (up_i && !down_i)      return DIR_UP;
    else if (!up_i && down_i) return DIR_DOWN;
    else                      return DIR_HOLD;
  endfunction

endpackage

// File: rtl/updn_dir_decode.sv
module updn_dir_decode
  import updn_pkg::*;
(
  input  logic inc_req,
  input  logic dec_req,
  output dir_e dir
);

  // Equal controls, both low or both high, select hold.
  always_comb begin
    dir = decode_dir(inc_req, dec_req);
  end

endmodule

// File: rtl/updn_toggle_gen.sv
module updn_toggle_gen
  import updn_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEFAULT
) (
  input  dir_e             dir,
  input  logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] toggle
);

  // lower_ones[i]: every bit below i is 1; lower_zeros[i]: every bit below i is 0
  logic [CNT_W-1:0] lower_ones;
  logic [CNT_W-1:0] lower_zeros;

  for (genvar i = 0; i < CNT_W; i++) begin : g_chain
    if (i == 0) begin : g_lsb
      assign lower_ones[i]  = 1'b1;
      assign lower_zeros[i] = 1'b1;
    end else begin : g_upper
      assign lower_ones[i]  = lower_ones[i-1]  &  cur[i-1];
      assign lower_zeros[i] = lower_zeros[i-1] & ~cur[i-1];
    end
    assign toggle[i] = ((dir == DIR_UP)   && lower_ones[i]) ||
                       ((dir == DIR_DOWN) && lower_zeros[i]);
  end

endmodule

// File: rtl/updn_tff.sv
module updn_tff (
  input  logic clk,
  input  logic rst,
  input  logic t,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)    q <= 1'b0;
    else if (t) q <= ~q;
  end

endmodule

// File: rtl/updn_counter2in.sv
module updn_counter2in
  import updn_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_req,
  input  logic             dec_req,
  output logic [CNT_W-1:0] count
);

  dir_e             dir;
  logic [CNT_W-1:0] toggle;
  logic [CNT_W-1:0] bits_q;

  updn_dir_decode u_dec (
    .inc_req (inc_req),
    .dec_req (dec_req),
    .dir     (dir)
  );

  updn_toggle_gen #(.CNT_W(CNT_W)) u_tgl (
    .dir    (dir),
    .cur    (bits_q),
    .toggle (toggle)
  );

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    updn_tff u_tff (
      .clk (clk),
      .rst (rst),
      .t   (toggle[i]),
      .q   (bits_q[i])
    );
  end

  assign count = bits_q;

endmodule

// File: rtl/updn_counter2in_chk.sv
module updn_counter2in_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             inc_req,
  input logic             dec_req,
  input logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0));

  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (inc_req && !dec_req) |=> (count == $past(count) + ONE));

  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (!inc_req && dec_req) |=> (count == $past(count) - ONE));

  a_r4_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!inc_req && !dec_req) |=> $stable(count));

  a_r5_hold_high: assert property (@(posedge clk) disable iff (rst)
    (inc_req && dec_req) |=> $stable(count));

  a_r6_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (inc_req && !dec_req && count == TOP) |=> (count == '0));

  a_r7_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (!inc_req && dec_req && count == '0) |=> (count == TOP));

endmodule

bind updn_counter2in updn_counter2in_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inc_req (inc_req),
  .dec_req (dec_req),
  .count   (count)
);

// File: tb/tb_updn_counter2in.sv
`timescale 1ns/1ps
module tb_updn_counter2in;

  localparam int W = 3;
  localparam int N_VEC = 12;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inc_req = 1'b0;
  logic         dec_req = 1'b0;
  logic [W-1:0] count;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  updn_counter2in #(.CNT_W(W)) dut (
    .clk     (clk),
    .rst     (rst),
    .inc_req (inc_req),
    .dec_req (dec_req),
    .count   (count)
  );

  // entry: {inc, dec, expected count after the edge}, walked from count 0
  localparam logic [4:0] VEC [N_VEC] = '{
    {2'b10, 3'd1}, {2'b10, 3'd2}, {2'b00, 3'd2}, {2'b01, 3'd1},
    {2'b11, 3'd1}, {2'b01, 3'd0}, {2'b01, 3'd7}, {2'b01, 3'd6},
    {2'b10, 3'd7}, {2'b10, 3'd0}, {2'b11, 3'd0}, {2'b10, 3'd1}
  };

  task automatic check(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (count !== exp) begin
      n_bad++;
      $display("FAIL %s: count actual %0d expected %0d", req, count, exp);
    end
  endtask

  task automatic step(input logic i_up, input logic i_dn);
    @(negedge clk);
    inc_req = i_up;
    dec_req = i_dn;
    @(posedge clk);
    #1;
  endtask

  function automatic string tag_of(input logic i_up, input logic i_dn, input logic [W-1:0] prev);
    if (i_up && !i_dn) return (prev == W'(MOD-1)) ? "R6" : "R2";
    if (!i_up && i_dn) return (prev == '0) ? "R7" : "R3";
    if (!i_up)         return "R4";
    return "R5";
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] exp;
    // reset state, R8
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset state", '0);
    @(negedge clk);
    rst = 1'b0;

    // vector table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < N_VEC; k++) begin
      logic [W-1:0] prev;
      prev = count;
      step(VEC[k][4], VEC[k][3]);
      check(tag_of(VEC[k][4], VEC[k][3], prev), VEC[k][2:0]);
    end

    // R1: full up sweep returns to 0 after exactly 2^W steps
    rst = 1'b1;
    step(1'b0, 1'b0);
    rst = 1'b0;
    exp = '0;
    for (int k = 0; k < MOD; k++) begin
      step(1'b1, 1'b0);
      exp = W'((int'(exp) + 1) % MOD);
      if (k < MOD - 1) check("R2 up sweep", exp);
    end
    check("R1 back to zero after full sweep", '0);

    // R3/R7: full down sweep
    for (int k = 0; k < MOD; k++) begin
      step(1'b0, 1'b1);
      exp = W'((int'(exp) + MOD - 1) % MOD);
      check(k == 0 ? "R7 wrap down" : "R3 down sweep", exp);
    end

    // R8: reset overrides an up request at a nonzero count
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R2 setup", 3'd2);
    @(negedge clk);
    rst = 1'b1;
    inc_req = 1'b1;
    dec_req = 1'b0;
    @(posedge clk);
    #1;
    check("R8 reset over up request", '0);
    @(negedge clk);
    rst = 1'b0;
    dec_req = 1'b1;
    inc_req = 1'b0;
    @(posedge clk);
    #1;
    check("R7 down right after reset", 3'd7);

    // R9: pulse between edges has no effect
    step(1'b0, 1'b0);
    check("R4 hold before pulse", 3'd7);
    @(negedge clk);
    inc_req = 1'b1;
    #1;
    inc_req = 1'b0;
    dec_req = 1'b1;
    #0.5;
    dec_req = 1'b0;
    @(posedge clk);
    #1;
    check("R9 mid-cycle pulse ignored", 3'd7);
    #1;
    check("R9 no change between edges", 3'd7);

    done = 1'b1;
    finish_run();
  end

endmodule